// File: doc/BRIEF.md
# Address Match Breakpoint Unit

This block watches a processor core's instruction fetches and data accesses. It raises a breakpoint-exception request when a fetch address or a load/store address equals the compare word of an armed hardware trigger. Each trigger has a control word and a compare word, both supplied by the core's trigger registers. The control word's format field selects one of two layouts. The older layout only has enables for the privilege levels of the host. The newer layout adds enables for the two guest levels used under virtualization. The unit checks the current privilege level and the virtualization flag against those enables. For data accesses it also checks the requested access size against the trigger's size field.

The unit looks at the fetch and memory request buses in the cycle a request is valid. It registers the outcome and presents it in the next cycle as a one-cycle request pulse. The pulse carries the index of the winning trigger, a flag telling an execute match from a memory match, and the address the trap handler should see. The core uses this pulse to take a breakpoint exception before the matching instruction retires or the matching access commits. Breakpoint-exception entry is the only action. Data-value matching, chaining, masked or range compares and debug-mode entry are not part of this unit.

Top module: `addr_match_bkpt`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, trapReq is low. trapIdx, trapIsExec and trapAddr are zero after reset.
- R2: A trigger whose control bits [XLEN-1:XLEN-4] hold format code 2 or 6, with the execute bit (bit 2) set and with its privilege filter passing, matches a valid fetch whose PC equals its compare word. One cycle later trapReq is high, trapIsExec is 1 and trapAddr equals the compare word.
- R3: A memory match needs the load bit (bit 0) when memWe=0, or the store bit (bit 1) when memWe=1, together with memAddr equal to the compare word. It gives trapReq with trapIsExec=0 and trapAddr equal to the compare word one cycle later. A load-only trigger ignores stores.
- R4: In format 2, the host enables are bit 3 for U (priv 0), bit 4 for S (priv 1) and bit 6 for M (priv 3). Privilege value 2 selects no enable. A format-2 trigger never fires while virtOn is high.
- R5: In format 6 with virtOn low, the host enable bits of R4 apply. With virtOn high, bit 23 enables guest U (priv 0) and bit 24 enables guest S (priv 1). With virtOn high and priv 3, nothing fires.
- R6: The size field is bits 17:16 in format 2 and bits 19:16 in format 6. Size codes: 1=byte, 2=half, 3=word, 5=double, compared against memSize, which uses the same codes. A field of 0, or any code outside that set, matches every access size. Execute matches ignore the size field.
- R7: A trigger fires only if at least one privilege enable and at least one of the load/store/execute bits are set. Format codes other than 2 and 6 never fire.
- R8: When several triggers match one request, trapIdx reports the lowest-indexed matching trigger.
- R9: When a fetch match and a memory match occur in the same cycle, the memory match is reported (trapIsExec=0, memory address).
- R10: trapReq is high for exactly one cycle per cycle with a matching valid request. With fetchValid and memValid low, no match is raised whatever the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigCtrl | input | NUM_TRIG*XLEN | Control words, trigger i in bits [i*XLEN +: XLEN] |
| trigCmp | input | NUM_TRIG*XLEN | Compare words, same packing |
| privLevel | input | 2 | Current privilege: 0=U, 1=S, 3=M |
| virtOn | input | 1 | Virtualization active |
| fetchValid | input | 1 | Fetch request valid |
| fetchPc | input | XLEN | Fetch address |
| memValid | input | 1 | Memory request valid |
| memWe | input | 1 | 1 = store, 0 = load |
| memAddr | input | XLEN | Memory request address |
| memSize | input | 4 | Access size code (1,2,3,5) |
| trapReq | output | 1 | Breakpoint request pulse |
| trapIsExec | output | 1 | 1 = execute match, 0 = memory match |
| trapIdx | output | IDXW | Winning trigger index |
| trapAddr | output | XLEN | Address reported for the trap value |

## Verification
The hardest situation to reach from the ports is a cycle in which a fetch match and a memory match occur together on different triggers. The index priority and the memory-over-fetch priority then both decide the result. The stimulus table programs two triggers with distinct compare words and presents a fetch and an access that each hit one of them, in both index orders. The guest-privilege cases also need several controls set at once. These are reached by vectors that each set the virtualization flag, the privilege and the guest enable bits together, so that each enable bit is seen passing in its own mode and blocked in the mode next to it.

// File: rtl/abm_pkg.sv
package abm_pkg;

  // Format codes held in the top nibble of a control word
  localparam logic [3:0] FMT_LEGACY = 4'd2;
  localparam logic [3:0] FMT_NEWER  = 4'd6;

  // Control word bit positions
  localparam int BIT_LOAD    = 0;
  localparam int BIT_STORE   = 1;
  localparam int BIT_EXEC    = 2;
  localparam int BIT_HOST_U  = 3;
  localparam int BIT_HOST_S  = 4;
  localparam int BIT_HOST_M  = 6;
  localparam int BIT_GUEST_U = 23;
  localparam int BIT_GUEST_S = 24;
  localparam int SIZE_LO     = 16;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  // Per-trigger strobes from the control decode to the compare datapath
  typedef struct packed {
    logic execArm;
    logic loadArm;
    logic storeArm;
  } armStrobe_t;

  // Size codes that restrict a memory match; all others behave as "any"
  function automatic logic sizeCodeKnown(input logic [3:0] code);
    return (code == 4'd1) || (code == 4'd2) || (code == 4'd3) || (code == 4'd5);
  endfunction

endpackage

// File: rtl/abm_ctrl.sv
module abm_ctrl
  import abm_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  input  logic [1:0]               privLevel,
  input  logic                     virtOn,
  input  logic [3:0]               memSize,
  output armStrobe_t [NUM_TRIG-1:0] arms
);

  localparam int FMT_HI = XLEN - 1;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic [XLEN-1:0] word;
    logic [3:0]      fmt;
    logic            isLegacy;
    logic            isNewer;
    logic            hostModeOk;
    logic            guestModeOk;
    logic            modeOk;
    logic            anyMode;
    logic            anyAccess;
    logic            enabled;
    logic [3:0]      sizeCode;
    logic            sizeOk;

    assign word     = trigCtrl[i*XLEN +: XLEN];
    assign fmt      = word[FMT_HI -: 4];
    assign isLegacy = (fmt == FMT_LEGACY);
    assign isNewer  = (fmt == FMT_NEWER);

    // Host privilege enable selected by the current level
    always_comb begin
      case (privLevel)
        PRIV_U:  hostModeOk = word[BIT_HOST_U];
        PRIV_S:  hostModeOk = word[BIT_HOST_S];
        PRIV_M:  hostModeOk = word[BIT_HOST_M];
        default: hostModeOk = 1'b0;
      endcase
    end

    // Guest privilege enable, only user and supervisor exist as guests
    always_comb begin
      case (privLevel)
        PRIV_U:  guestModeOk = word[BIT_GUEST_U];
        PRIV_S:  guestModeOk = word[BIT_GUEST_S];
        default: guestModeOk = 1'b0;
      endcase
    end

    always_comb begin
      if (isLegacy)     modeOk = !virtOn && hostModeOk;
      else if (isNewer) modeOk = virtOn ? guestModeOk : hostModeOk;
      else              modeOk = 1'b0;
    end

    assign anyMode = word[BIT_HOST_U] | word[BIT_HOST_S] | word[BIT_HOST_M]
                   | (isNewer & (word[BIT_GUEST_U] | word[BIT_GUEST_S]));
    assign anyAccess = word[BIT_LOAD] | word[BIT_STORE] | word[BIT_EXEC];
    assign enabled   = (isLegacy || isNewer) && anyMode && anyAccess;

    assign sizeCode = isLegacy ? {2'b00, word[SIZE_LO+1:SIZE_LO]}
                               : word[SIZE_LO+3:SIZE_LO];
    assign sizeOk   = (sizeCode == 4'd0) || !sizeCodeKnown(sizeCode)
                   || (sizeCode == memSize);

    assign arms[i].execArm  = enabled && modeOk && word[BIT_EXEC];
    assign arms[i].loadArm  = enabled && modeOk && sizeOk && word[BIT_LOAD];
    assign arms[i].storeArm = enabled && modeOk && sizeOk && word[BIT_STORE];

    AST_LEGACY_QUIET_VIRT: assert property (@(posedge clk) disable iff (!rstN)
      (virtOn && (trigCtrl[i*XLEN+XLEN-1 -: 4] == FMT_LEGACY)) |-> (arms[i] == '0)); // R4
    AST_RESERVED_PRIV_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (privLevel == 2'd2) |-> (arms[i] == '0)); // R4
    AST_GUEST_M_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      (virtOn && (privLevel == PRIV_M)) |-> (arms[i] == '0)); // R5
    AST_UNKNOWN_FMT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
      ((trigCtrl[i*XLEN+XLEN-1 -: 4] != FMT_LEGACY) &&
       (trigCtrl[i*XLEN+XLEN-1 -: 4] != FMT_NEWER)) |-> (arms[i] == '0)); // R7
  end

endmodule

// File: rtl/abm_datapath.sv
module abm_datapath
  import abm_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  parameter int XLEN     = 32,
  parameter int IDXW     = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_TRIG*XLEN-1:0]  trigCmp,
  input  armStrobe_t [NUM_TRIG-1:0] arms,
  input  logic                      fetchValid,
  input  logic [XLEN-1:0]           fetchPc,
  input  logic                      memValid,
  input  logic                      memWe,
  input  logic [XLEN-1:0]           memAddr,
  output logic                      trapReq,
  output logic                      trapIsExec,
  output logic [IDXW-1:0]           trapIdx,
  output logic [XLEN-1:0]           trapAddr
);

  logic [NUM_TRIG-1:0] execHit;
  logic [NUM_TRIG-1:0] memHit;
  logic [IDXW-1:0]     execIdx;
  logic [IDXW-1:0]     memIdx;
  logic [XLEN-1:0]     execAddr;
  logic [XLEN-1:0]     memHitAddr;
  logic                anyExec;
  logic                anyMem;

  // One full-width comparator per trigger and per bus
  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_cmp
    logic [XLEN-1:0] cmpWord;
    logic            accessArm;
    assign cmpWord    = trigCmp[i*XLEN +: XLEN];
    assign accessArm  = memWe ? arms[i].storeArm : arms[i].loadArm;
    assign execHit[i] = fetchValid && arms[i].execArm && (cmpWord == fetchPc);
    assign memHit[i]  = memValid && accessArm && (cmpWord == memAddr);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    execIdx    = '0;
    memIdx     = '0;
    execAddr   = '0;
    memHitAddr = '0;
    for (int k = NUM_TRIG - 1; k >= 0; k--) begin
      if (execHit[k]) begin
        execIdx  = IDXW'(k);
        execAddr = trigCmp[k*XLEN +: XLEN];
      end
      if (memHit[k]) begin
        memIdx     = IDXW'(k);
        memHitAddr = trigCmp[k*XLEN +: XLEN];
      end
    end
  end

  assign anyExec = |execHit;
  assign anyMem  = |memHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapReq    <= 1'b0;
      trapIsExec <= 1'b0;
      trapIdx    <= '0;
      trapAddr   <= '0;
    end else begin
      trapReq <= anyExec || anyMem;
      if (anyMem) begin
        trapIsExec <= 1'b0;
        trapIdx    <= memIdx;
        trapAddr   <= memHitAddr;
      end else if (anyExec) begin
        trapIsExec <= 1'b1;
        trapIdx    <= execIdx;
        trapAddr   <= execAddr;
      end
    end
  end

  AST_REQ_BACKED: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(fetchValid || memValid)); // R10
  AST_EXEC_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && trapIsExec) |-> (trapAddr == $past(fetchPc))); // R2
  AST_MEM_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !trapIsExec) |-> (trapAddr == $past(memAddr))); // R3
  AST_MEM_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    anyMem |=> (trapReq && !trapIsExec)); // R9
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (int'(trapIdx) < NUM_TRIG)); // R8

endmodule

// File: rtl/addr_match_bkpt.sv
module addr_match_bkpt
  import abm_pkg::*;
#(
  parameter  int NUM_TRIG = 4,
  parameter  int XLEN     = 32,
  localparam int IDXW     = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_TRIG*XLEN-1:0] trigCtrl,
  input  logic [NUM_TRIG*XLEN-1:0] trigCmp,
  input  logic [1:0]               privLevel,
  input  logic                     virtOn,
  input  logic                     fetchValid,
  input  logic [XLEN-1:0]          fetchPc,
  input  logic                     memValid,
  input  logic                     memWe,
  input  logic [XLEN-1:0]          memAddr,
  input  logic [3:0]               memSize,
  output logic                     trapReq,
  output logic                     trapIsExec,
  output logic [IDXW-1:0]          trapIdx,
  output logic [XLEN-1:0]          trapAddr
);

  armStrobe_t [NUM_TRIG-1:0] arms;

  abm_ctrl #(
    .NUM_TRIG (NUM_TRIG),
    .XLEN     (XLEN)
  ) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigCtrl  (trigCtrl),
    .privLevel (privLevel),
    .virtOn    (virtOn),
    .memSize   (memSize),
    .arms      (arms)
  );

  abm_datapath #(
    .NUM_TRIG (NUM_TRIG),
    .XLEN     (XLEN),
    .IDXW     (IDXW)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .trigCmp    (trigCmp),
    .arms       (arms),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc),
    .memValid   (memValid),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .trapReq    (trapReq),
    .trapIsExec (trapIsExec),
    .trapIdx    (trapIdx),
    .trapAddr   (trapAddr)
  );

endmodule

// File: tb/test_addr_match_bkpt.sv
module test_addr_match_bkpt;

  localparam int NT = 4;
  localparam int XL = 32;
  localparam int IW = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rstN;
  logic [NT*XL-1:0] trigCtrl;
  logic [NT*XL-1:0] trigCmp;
  logic [1:0]     privLevel;
  logic           virtOn;
  logic           fetchValid;
  logic [XL-1:0]  fetchPc;
  logic           memValid;
  logic           memWe;
  logic [XL-1:0]  memAddr;
  logic [3:0]     memSize;
  logic           trapReq;
  logic           trapIsExec;
  logic [IW-1:0]  trapIdx;
  logic [XL-1:0]  trapAddr;

  addr_match_bkpt #(.NUM_TRIG(NT), .XLEN(XL)) i_addr_match_bkpt (
    .clk(clk), .rstN(rstN), .trigCtrl(trigCtrl), .trigCmp(trigCmp),
    .privLevel(privLevel), .virtOn(virtOn), .fetchValid(fetchValid),
    .fetchPc(fetchPc), .memValid(memValid), .memWe(memWe), .memAddr(memAddr),
    .memSize(memSize), .trapReq(trapReq), .trapIsExec(trapIsExec),
    .trapIdx(trapIdx), .trapAddr(trapAddr)
  );

  // Control word building blocks (encodings from the requirements)
  localparam logic [31:0] T2  = 32'h2000_0000;
  localparam logic [31:0] T6  = 32'h6000_0000;
  localparam logic [31:0] TX  = 32'h3000_0000;
  localparam logic [31:0] BL  = 32'h0000_0001;
  localparam logic [31:0] BS  = 32'h0000_0002;
  localparam logic [31:0] BX  = 32'h0000_0004;
  localparam logic [31:0] BU  = 32'h0000_0008;
  localparam logic [31:0] BSV = 32'h0000_0010;
  localparam logic [31:0] B5  = 32'h0000_0020;
  localparam logic [31:0] BM  = 32'h0000_0040;
  localparam logic [31:0] BVU = 32'h0080_0000;
  localparam logic [31:0] BVS = 32'h0100_0000;
  localparam logic [31:0] SW2 = 32'h0003_0000;
  localparam logic [31:0] SD6 = 32'h0005_0000;
  localparam logic [31:0] S46 = 32'h0004_0000;
  localparam logic [31:0] A   = 32'h0000_1000;
  localparam logic [31:0] A4  = 32'h0000_1004;
  localparam logic [31:0] B   = 32'h0000_2000;
  localparam logic [31:0] C   = 32'h0000_3000;
  localparam logic [31:0] Z   = 32'h0000_0000;

  typedef struct packed {
    logic [31:0] c0;
    logic [31:0] cmp0;
    logic [31:0] c1;
    logic [31:0] cmp1;
    logic [1:0]  pv;
    logic        vt;
    logic        fv;
    logic [31:0] pc;
    logic        mv;
    logic        we;
    logic [31:0] ad;
    logic [3:0]  sz;
    logic        eR;
    logic        eX;
    logic [1:0]  eI;
    logic [31:0] eA;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{T2|BM|BX, A, Z, Z, 2'd3, 1'b0, 1'b1, A,  1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd0, A, 4'd2},  // R2 exec hit in M
    '{T2|BM|BX, A, Z, Z, 2'd3, 1'b0, 1'b1, A4, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd2},  // R2 pc differs
    '{T2|BM|BX, A, Z, Z, 2'd0, 1'b0, 1'b1, A,  1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd4},  // R4 M-only in U
    '{T2|BU|BX, A, Z, Z, 2'd0, 1'b1, 1'b1, A,  1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd4},  // R4 legacy under virt
    '{T2|BU|BX, A, Z, Z, 2'd0, 1'b0, 1'b1, A,  1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd0, A, 4'd4},  // R4 legacy U
    '{T6|BVU|BX, A, Z, Z, 2'd0, 1'b1, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd0, A, 4'd5},  // R5 guest U
    '{T6|BVU|BX, A, Z, Z, 2'd1, 1'b1, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd5},  // R5 VU bit in guest S
    '{T6|BVS|BX, A, Z, Z, 2'd1, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd5},  // R5 VS bit, virt off
    '{T6|BVS|BX, A, Z, Z, 2'd1, 1'b1, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd0, A, 4'd5},  // R5 guest S
    '{T6|BU|BX, A, Z, Z, 2'd0, 1'b0, 1'b1, A,  1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd0, A, 4'd5},  // R5 host U in format 6
    '{T2|BM|BL, B, Z, Z, 2'd3, 1'b0, 1'b0, Z,  1'b1, 1'b0, B, 4'd3, 1'b1, 1'b0, 2'd0, B, 4'd3},  // R3 load hit
    '{T2|BM|BL, B, Z, Z, 2'd3, 1'b0, 1'b0, Z,  1'b1, 1'b1, B, 4'd3, 1'b0, 1'b0, 2'd0, Z, 4'd3},  // R3 store to load-only
    '{T2|BSV|BS, B, Z, Z, 2'd1, 1'b0, 1'b0, Z, 1'b1, 1'b1, B, 4'd3, 1'b1, 1'b0, 2'd0, B, 4'd3},  // R3 store hit in S
    '{T2|BM|BL|SW2, B, Z, Z, 2'd3, 1'b0, 1'b0, Z, 1'b1, 1'b0, B, 4'd1, 1'b0, 1'b0, 2'd0, Z, 4'd6}, // R6 word vs byte
    '{T2|BM|BL|SW2, B, Z, Z, 2'd3, 1'b0, 1'b0, Z, 1'b1, 1'b0, B, 4'd3, 1'b1, 1'b0, 2'd0, B, 4'd6}, // R6 word vs word
    '{T6|BM|BS|SD6, B, Z, Z, 2'd3, 1'b0, 1'b0, Z, 1'b1, 1'b1, B, 4'd5, 1'b1, 1'b0, 2'd0, B, 4'd6}, // R6 double vs double
    '{T6|BM|BS|SD6, B, Z, Z, 2'd3, 1'b0, 1'b0, Z, 1'b1, 1'b1, B, 4'd3, 1'b0, 1'b0, 2'd0, Z, 4'd6}, // R6 double vs word
    '{T6|BM|BL|S46, B, Z, Z, 2'd3, 1'b0, 1'b0, Z, 1'b1, 1'b0, B, 4'd1, 1'b1, 1'b0, 2'd0, B, 4'd6}, // R6 unknown code = any
    '{T2|BM|BX|SW2, A, Z, Z, 2'd3, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd0, A, 4'd6}, // R6 exec ignores size
    '{T2|BX, A, Z, Z, 2'd3, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd7},       // R7 no mode bit
    '{T2|BM, A, Z, Z, 2'd3, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd7},       // R7 no access bit
    '{TX|BM|BX, A, Z, Z, 2'd3, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd7},    // R7 other format
    '{T2|BM|BX, A, T2|BM|BX, A, 2'd3, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd0, A, 4'd8}, // R8 both hit
    '{T2|BM|BX, C, T2|BM|BX, A, 2'd3, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b1, 1'b1, 2'd1, A, 4'd8}, // R8 only trigger 1
    '{T2|BM|BL, C, T2|BM|BX, A, 2'd3, 1'b0, 1'b1, A, 1'b1, 1'b0, C, 4'd3, 1'b1, 1'b0, 2'd0, C, 4'd9}, // R9 mem on 0, fetch on 1
    '{T2|BM|BX, A, T2|BM|BS, C, 2'd3, 1'b0, 1'b1, A, 1'b1, 1'b1, C, 4'd3, 1'b1, 1'b0, 2'd1, C, 4'd9}, // R9 fetch on 0, mem on 1
    '{T2|BM|BX, A, Z, Z, 2'd3, 1'b0, 1'b0, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd10},  // R10 fetch not valid
    '{T2|BU|BSV|B5|BM|BX, A, Z, Z, 2'd2, 1'b0, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd4}, // R4 priv 2
    '{T6|BVU|BVS|BU|BSV|BM|BX, A, Z, Z, 2'd3, 1'b1, 1'b1, A, 1'b0, 1'b0, Z, 4'd0, 1'b0, 1'b0, 2'd0, Z, 4'd5}, // R5 virt with M
    '{T6|BM|BL, B, Z, Z, 2'd3, 1'b0, 1'b0, Z, 1'b0, 1'b0, B, 4'd3, 1'b0, 1'b0, 2'd0, Z, 4'd10}    // R10 mem not valid
  };

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  task automatic check(input string what, input int rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idleInputs();
    trigCtrl   = '0;
    trigCmp    = '0;
    privLevel  = 2'd3;
    virtOn     = 1'b0;
    fetchValid = 1'b0;
    fetchPc    = '0;
    memValid   = 1'b0;
    memWe      = 1'b0;
    memAddr    = '0;
    memSize    = 4'd0;
  endtask

  task automatic armExecM();
    trigCtrl   = {96'h0, T2 | BM | BX};
    trigCmp    = {96'h0, A};
    privLevel  = 2'd3;
    fetchValid = 1'b1;
    fetchPc    = A;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    idleInputs();
    // R1: a matching request during reset must not raise anything
    @(negedge clk);
    armExecM();
    repeat (3) @(negedge clk);
    check("trapReq in reset", 1, {31'b0, trapReq}, 32'h0);            // R1
    check("trapAddr in reset", 1, trapAddr, 32'h0);                   // R1
    idleInputs();
    rstN = 1'b1;
    @(negedge clk);
    check("trapReq after reset", 1, {31'b0, trapReq}, 32'h0);         // R1
    check("trapIdx after reset", 1, {30'b0, trapIdx}, 32'h0);         // R1
    check("trapIsExec after reset", 1, {31'b0, trapIsExec}, 32'h0);   // R1

    // Table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = VECS[v];
      trigCtrl   = {64'h0, t.c1, t.c0};
      trigCmp    = {64'h0, t.cmp1, t.cmp0};
      privLevel  = t.pv;
      virtOn     = t.vt;
      fetchValid = t.fv;
      fetchPc    = t.pc;
      memValid   = t.mv;
      memWe      = t.we;
      memAddr    = t.ad;
      memSize    = t.sz;
      @(negedge clk);
      fetchValid = 1'b0;
      memValid   = 1'b0;
      check($sformatf("vec %0d trapReq", v), int'(t.rq), {31'b0, trapReq}, {31'b0, t.eR});
      if (t.eR) begin
        check($sformatf("vec %0d trapIsExec", v), int'(t.rq), {31'b0, trapIsExec}, {31'b0, t.eX});
        check($sformatf("vec %0d trapIdx", v), int'(t.rq), {30'b0, trapIdx}, {30'b0, t.eI});
        check($sformatf("vec %0d trapAddr", v), int'(t.rq), trapAddr, t.eA);
      end
      @(negedge clk);
      check($sformatf("vec %0d pulse ends", v), 10, {31'b0, trapReq}, 32'h0);  // R10
    end

    // R10: back-to-back matching requests give one pulse each, then stop
    idleInputs();
    armExecM();
    @(negedge clk);
    check("first of two", 10, {31'b0, trapReq}, 32'h1);               // R10
    @(negedge clk);
    check("second of two", 10, {31'b0, trapReq}, 32'h1);              // R10
    fetchValid = 1'b0;
    @(negedge clk);
    check("after last request", 10, {31'b0, trapReq}, 32'h0);         // R10

    // R1: reset during a matching request clears the outputs
    armExecM();
    rstN = 1'b0;
    @(negedge clk);
    check("trapReq mid reset", 1, {31'b0, trapReq}, 32'h0);           // R1
    check("trapIsExec mid reset", 1, {31'b0, trapIsExec}, 32'h0);     // R1
    idleInputs();
    rstN = 1'b1;
    @(negedge clk);
    check("trapReq after mid reset", 1, {31'b0, trapReq}, 32'h0);     // R1

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule